// File: doc/BRIEF.md
# SPI Command Front End for a Battery-Free Backed SRAM

This block is the serial slave side of a small SRAM whose contents are mirrored into nonvolatile cells by a separate save/load controller. A host talks to it over a four-wire SPI bus in mode 0. Each transaction opens with an 8-bit command byte. The block decodes that byte into one of five kinds of work: status register access, write-enable control, array read/write with a 3-byte address, access to a 16-entry clock register file, or a one-cycle request to the save/load controller.

The bus pins are oversampled on the system clock through synchronizers. The block drives the memory port with single-cycle read and write strobes. It holds a write-enable latch and a status byte. The status byte has two block-protect bits that select how much of the top of the array refuses writes.

After reset the block does not consider itself selected until it sees a real high-to-low transition of chip select. A host that holds chip select low through reset therefore cannot start a command. The protect-enable flag and the two block-protect bits model nonvolatile state and are left untouched by reset.

Top module: `spi_nv_cmd_decoder`

## Requirements
- R1: A transaction begins only on a high-to-low transition of cs_ni. Bits are taken MSB first. The first 8 bits form the command byte. A low-to-high transition of cs_ni ends the transaction at any point.
- R2: After reset the block is deselected. If cs_ni is low throughout and after reset, no command is decoded (no strobe, no request pulse, no latch change) until cs_ni has gone high and then low again.
- R3: The status byte is {prot_en[7], scratch[6:4], blk_prot[3:2], wen[1], busy[0]}. Reset clears wen and scratch. Reset leaves prot_en and blk_prot at their previous values. Bit 0 reads busy_i.
- R4: Command 0x06 sets the write-enable latch and 0x04 clears it.
- R5: Command 0x05 returns the status byte on MISO and repeats it for every further byte. Command 0x01 loads bits 7, 6:4 and 3:2 from the next byte, but only when the latch is set.
- R6: Command 0x03 takes 3 address bytes and keeps the low 17 bits. It then returns sequential array bytes, and the address wraps from 0x1FFFF to 0.
- R7: Command 0x02 takes 3 address bytes. Each following data byte is written with one mem_we_o pulse at an auto-incremented, wrapping address, but only when the latch is set.
- R8: After a WRITE (0x02) or status write (0x01) that received at least one full data byte, the latch clears when cs_ni rises.
- R9: Writes are dropped in the protected region. blk_prot 00 protects nothing, 01 protects 0x18000-0x1FFFF, 10 protects 0x10000-0x1FFFF and 11 protects the whole array.
- R10: Command 0x12 writes and 0x13 reads the 16 clock registers. Each takes one index byte (low 4 bits), then auto-increments the index with wrap. Writes need the latch set and do not clear it.
- R11: Commands 0x3C, 0x60, 0x59 and 0x19 raise save_req_o, load_req_o, auto_on_req_o and auto_off_req_o respectively. Each is a single-cycle pulse, and at most one request is high at a time.
- R12: If busy_i is high when the command byte completes, the whole transaction is ignored: no pulse, no latch change, and MISO stays disabled.
- R13: An undefined or reserved command (e.g. 0x1E) is ignored. miso_oe_o stays low and later bytes have no effect until cs_ni rises.
- R14: MOSI is sampled on SCK rising edges. MISO changes on SCK falling edges. The first read bit is valid after the falling edge that follows the last command or address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| miso_oe_o | output | 1 | Output enable for MISO pad (low = high impedance) |
| busy_i | input | 1 | Save/load controller busy, including power-up load |
| mem_addr_o | output | 17 | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write strobe, one cycle |
| mem_re_o | output | 1 | Array read strobe, one cycle |
| mem_rdata_i | input | 8 | Array read data, sampled at the end of the mem_re_o cycle |
| save_req_o | output | 1 | Request: copy SRAM to nonvolatile cells |
| load_req_o | output | 1 | Request: copy nonvolatile cells to SRAM |
| auto_on_req_o | output | 1 | Request: enable automatic save on power loss |
| auto_off_req_o | output | 1 | Request: disable automatic save on power loss |

## Verification
The hardest case to reach is a chip select that is already low when reset releases. An ordinary host task always produces a falling edge, so it can never create this condition. The bench therefore holds cs_ni low across reset and clocks a complete save command and, in a second run, a write-enable command, without ever raising chip select first. It then confirms that no request pulse appeared and that the latch is still clear. Busy-time rejection is reached in a similar way: busy_i is raised before the command byte finishes, so the decode happens exactly while the controller reports busy.

// File: rtl/spi_nv_pkg.sv
package spi_nv_pkg;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_SR_READ   = 8'h05;
  localparam logic [7:0] OP_SR_WRITE  = 8'h01;
  localparam logic [7:0] OP_MEM_READ  = 8'h03;
  localparam logic [7:0] OP_MEM_WRITE = 8'h02;
  localparam logic [7:0] OP_CLK_WRITE = 8'h12;
  localparam logic [7:0] OP_CLK_READ  = 8'h13;
  localparam logic [7:0] OP_NV_SAVE   = 8'h3C;
  localparam logic [7:0] OP_NV_LOAD   = 8'h60;
  localparam logic [7:0] OP_AUTO_ON   = 8'h59;
  localparam logic [7:0] OP_AUTO_OFF  = 8'h19;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_MEM_RD, ST_MEM_WR,
    ST_CLK_RD, ST_CLK_WR, ST_SR_RD, ST_SR_WR, ST_IGNORE
  } state_t;

  typedef struct packed {
    logic auto_off;
    logic auto_on;
    logic load;
    logic save;
  } nv_req_t;
endpackage

// File: rtl/spi_nv_sync.sv
module spi_nv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_nv_prot_guard.sv
module spi_nv_prot_guard #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        blk_prot_i,
  output logic              blocked_o
);
  always_comb begin
    case (blk_prot_i)
      2'b00:   blocked_o = 1'b0;
      2'b01:   blocked_o = &addr_i[ADDR_W-1:ADDR_W-2];
      2'b10:   blocked_o = addr_i[ADDR_W-1];
      default: blocked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_nv_cmd_decoder.sv
module spi_nv_cmd_decoder
  import spi_nv_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int ADDR_BYTES  = 3,
  parameter int CLK_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              save_req_o,
  output logic              load_req_o,
  output logic              auto_on_req_o,
  output logic              auto_off_req_o
);
  localparam int CLK_IW = $clog2(CLK_REGS);
  localparam int HI_W   = ADDR_W - 8;
  localparam logic [1:0] LAST_AB = 2'(ADDR_BYTES - 1);

  // pin synchronizers; reset value 0 on chip select means a low pin yields no edge
  logic [2:0] pin_raw, pin_s;
  assign pin_raw = {mosi_i, cs_ni, sck_i};
  for (genvar gi = 0; gi < 3; gi++) begin : g_sync
    spi_nv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[gi]),
      .q_o   (pin_s[gi])
    );
  end

  logic sck_s, cs_s, mosi_s, sck_q, cs_q;
  assign sck_s  = pin_s[0];
  assign cs_s   = pin_s[1];
  assign mosi_s = pin_s[2];

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  state_t              state_q;
  logic [2:0]          bit_cnt_q;
  logic [1:0]          byte_cnt_q;
  logic [7:0]          sh_q, op_q, tx_q;
  logic [HI_W-1:0]     addr_hi_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CLK_IW-1:0]   clk_idx_q;
  logic                miso_q, oe_q, wen_q, clr_pend_q;
  logic [2:0]          scratch_q;
  logic                prot_en_q;
  logic [1:0]          bp_q;
  nv_req_t             req_q;
  logic [7:0]          clk_regs_q [CLK_REGS];

  logic [7:0]        byte_in, status_byte;
  logic              byte_done, wr_blocked, sr_we, clk_we, clk_op, addr_last;
  logic [ADDR_W-1:0] addr_full;

  assign byte_in     = {sh_q[6:0], mosi_s};
  assign byte_done   = sck_rise && (bit_cnt_q == 3'd7) && (state_q != ST_IDLE);
  assign addr_full   = {addr_hi_q, byte_in};
  assign status_byte = {prot_en_q, scratch_q, bp_q, wen_q, busy_i};
  assign clk_op      = (op_q == OP_CLK_WRITE) || (op_q == OP_CLK_READ);
  assign addr_last   = clk_op ? (byte_cnt_q == 2'd0) : (byte_cnt_q == LAST_AB);
  assign sr_we       = (state_q == ST_SR_WR) && byte_done && wen_q;
  assign clk_we      = (state_q == ST_CLK_WR) && byte_done && wen_q;

  spi_nv_prot_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr_i    (addr_q),
    .blk_prot_i(bp_q),
    .blocked_o (wr_blocked)
  );

  // nonvolatile-modelled bits: no reset
  always_ff @(posedge clk_i) begin
    if (sr_we) begin
      prot_en_q <= byte_in[7];
      bp_q      <= byte_in[3:2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CLK_REGS; i++) clk_regs_q[i] <= '0;
    end else if (clk_we) begin
      clk_regs_q[clk_idx_q] <= byte_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      cs_q        <= 1'b0;
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      byte_cnt_q  <= '0;
      sh_q        <= '0;
      op_q        <= '0;
      tx_q        <= '0;
      addr_hi_q   <= '0;
      addr_q      <= '0;
      clk_idx_q   <= '0;
      miso_q      <= 1'b0;
      oe_q        <= 1'b0;
      wen_q       <= 1'b0;
      clr_pend_q  <= 1'b0;
      scratch_q   <= '0;
      req_q       <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      cs_q     <= cs_s;
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      req_q    <= '0;
      if (mem_re_o) tx_q <= mem_rdata_i;

      if (cs_rise) begin
        state_q    <= ST_IDLE;
        oe_q       <= 1'b0;
        clr_pend_q <= 1'b0;
        if (clr_pend_q) wen_q <= 1'b0;
      end else if (cs_fall) begin
        state_q    <= ST_OP;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        oe_q       <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (sck_fall && oe_q) begin
          miso_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
        if (sck_rise) begin
          sh_q      <= byte_in;
          bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        if (byte_done) begin
          case (state_q)
            ST_OP: begin
              op_q    <= byte_in;
              state_q <= ST_IGNORE;
              if (!busy_i) begin
                case (byte_in)
                  OP_WR_EN:    wen_q <= 1'b1;
                  OP_WR_DIS:   wen_q <= 1'b0;
                  OP_SR_READ: begin
                    tx_q    <= status_byte;
                    oe_q    <= 1'b1;
                    state_q <= ST_SR_RD;
                  end
                  OP_SR_WRITE: state_q <= ST_SR_WR;
                  OP_MEM_READ, OP_MEM_WRITE,
                  OP_CLK_WRITE, OP_CLK_READ: state_q <= ST_ADDR;
                  OP_NV_SAVE:  req_q.save     <= 1'b1;
                  OP_NV_LOAD:  req_q.load     <= 1'b1;
                  OP_AUTO_ON:  req_q.auto_on  <= 1'b1;
                  OP_AUTO_OFF: req_q.auto_off <= 1'b1;
                  default: ;
                endcase
              end
            end
            ST_ADDR: begin
              addr_hi_q  <= addr_full[HI_W-1:0];
              byte_cnt_q <= byte_cnt_q + 2'd1;
              if (addr_last) begin
                case (op_q)
                  OP_MEM_READ: begin
                    mem_addr_o <= addr_full;
                    mem_re_o   <= 1'b1;
                    addr_q     <= addr_full + 1'b1;
                    oe_q       <= 1'b1;
                    state_q    <= ST_MEM_RD;
                  end
                  OP_MEM_WRITE: begin
                    addr_q  <= addr_full;
                    state_q <= ST_MEM_WR;
                  end
                  OP_CLK_READ: begin
                    tx_q      <= clk_regs_q[byte_in[CLK_IW-1:0]];
                    clk_idx_q <= byte_in[CLK_IW-1:0] + 1'b1;
                    oe_q      <= 1'b1;
                    state_q   <= ST_CLK_RD;
                  end
                  default: begin
                    clk_idx_q <= byte_in[CLK_IW-1:0];
                    state_q   <= ST_CLK_WR;
                  end
                endcase
              end
            end
            ST_MEM_RD: begin
              mem_addr_o <= addr_q;
              mem_re_o   <= 1'b1;
              addr_q     <= addr_q + 1'b1;
            end
            ST_MEM_WR: begin
              if (wen_q && !wr_blocked) begin
                mem_we_o    <= 1'b1;
                mem_addr_o  <= addr_q;
                mem_wdata_o <= byte_in;
              end
              addr_q     <= addr_q + 1'b1;
              clr_pend_q <= 1'b1;
            end
            ST_CLK_RD: begin
              tx_q      <= clk_regs_q[clk_idx_q];
              clk_idx_q <= clk_idx_q + 1'b1;
            end
            ST_CLK_WR: clk_idx_q <= clk_idx_q + 1'b1;
            ST_SR_RD:  tx_q <= status_byte;
            ST_SR_WR: begin
              if (wen_q) scratch_q <= byte_in[6:4];
              clr_pend_q <= 1'b1;
              state_q    <= ST_IGNORE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign miso_o         = miso_q;
  assign miso_oe_o      = oe_q;
  assign save_req_o     = req_q.save;
  assign load_req_o     = req_q.load;
  assign auto_on_req_o  = req_q.auto_on;
  assign auto_off_req_o = req_q.auto_off;
endmodule

// File: rtl/spi_nv_cmd_decoder_chk.sv
module spi_nv_cmd_decoder_chk
  import spi_nv_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              save_req_o,
  input logic              load_req_o,
  input logic              auto_on_req_o,
  input logic              auto_off_req_o,
  input logic              busy_i,
  input logic              miso_oe_o,
  input logic              wen_q,
  input logic [1:0]        bp_q,
  input state_t            state_q
);
  logic [3:0] reqs;
  assign reqs = {auto_off_req_o, auto_on_req_o, load_req_o, save_req_o};

  a_r7_write_needs_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(wen_q));

  a_r9_no_protected_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !((bp_q == 2'b11) ||
                   (bp_q == 2'b10 && mem_addr_o[ADDR_W-1]) ||
                   (bp_q == 2'b01 && mem_addr_o[ADDR_W-1] && mem_addr_o[ADDR_W-2])));

  a_r11_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reqs));

  a_r11_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reqs != 4'b0) |=> (reqs == 4'b0));

  a_r12_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reqs != 4'b0) |-> !$past(busy_i));

  a_r6_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r13_ignore_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !miso_oe_o);
endmodule

bind spi_nv_cmd_decoder spi_nv_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_we_o      (mem_we_o),
  .mem_re_o      (mem_re_o),
  .mem_addr_o    (mem_addr_o),
  .save_req_o    (save_req_o),
  .load_req_o    (load_req_o),
  .auto_on_req_o (auto_on_req_o),
  .auto_off_req_o(auto_off_req_o),
  .busy_i        (busy_i),
  .miso_oe_o     (miso_oe_o),
  .wen_q         (wen_q),
  .bp_q          (bp_q),
  .state_q       (state_q)
);

// File: tb/spi_nv_cmd_decoder_tb.sv
module spi_nv_cmd_decoder_tb;
  localparam int HALF = 6;
  typedef logic [7:0] bq_t[$];
  typedef struct { int a; logic [7:0] d; } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic miso, miso_oe, mem_we, mem_re;
  logic save_r, load_r, aon_r, aoff_r;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  always #5 clk = ~clk;

  spi_nv_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .busy_i(busy),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .save_req_o(save_r), .load_req_o(load_r),
    .auto_on_req_o(aon_r), .auto_off_req_o(aoff_r)
  );

  int errs = 0, checks = 0;
  string cur_req = "R1";
  wr_t wr_q[$];
  logic [3:0] pl_q[$];
  logic [7:0] dut_mem[int];
  logic [7:0] exp_mem[int];
  logic [7:0] clk_m[16];
  logic wen_m = 1'b0, pen_m = 1'b0;
  logic [2:0] scr_m = 3'b0;
  logic [1:0] bp_m = 2'b0;
  wr_t we_e;
  logic [3:0] pl_e, pl_now;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL [%s] %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of strobes and request pulses against the model queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (wr_q.size() == 0) chk(0, cur_req, "unexpected write", {15'd0, mem_addr}, 0);
        else begin
          we_e = wr_q.pop_front();
          chk(we_e.a == int'(mem_addr) && we_e.d == mem_wdata, cur_req, "write addr/data",
              {7'd0, mem_addr, mem_wdata}, {7'd0, we_e.a[16:0], we_e.d});
        end
        dut_mem[int'(mem_addr)] = mem_wdata;
      end
      if (mem_re) mem_rdata = dut_mem.exists(int'(mem_addr)) ? dut_mem[int'(mem_addr)] : 8'h00;
      pl_now = {aoff_r, aon_r, load_r, save_r};
      if (pl_now != 4'b0) begin
        if (pl_q.size() == 0) chk(0, cur_req, "unexpected request pulse", pl_now, 0);
        else begin
          pl_e = pl_q.pop_front();
          chk(pl_now == pl_e, cur_req, "request pulse", pl_now, pl_e);
        end
      end
    end
  end

  task automatic xfer(input bq_t tx, output bq_t rx, output bit saw_oe, input bit no_fall);
    logic [7:0] r;
    rx = {};
    saw_oe = 1'b0;
    @(negedge clk);
    if (!no_fall) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (tx[k]) begin
      r = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        mosi = tx[k][i];
        repeat (HALF) @(negedge clk);
        r = {r[6:0], miso};
        saw_oe |= miso_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
      rx.push_back(r);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic settle(input string req);
    chk(wr_q.size() == 0 && pl_q.size() == 0, req, "strobes outstanding",
        wr_q.size() + pl_q.size(), 0);
  endtask

  task automatic cmd(input bq_t tx);
    bq_t rx;
    bit so;
    xfer(tx, rx, so, 1'b0);
  endtask

  function automatic logic [7:0] status_m();
    return {pen_m, scr_m, bp_m, wen_m, busy};
  endfunction

  function automatic bit prot(input int a);
    case (bp_m)
      2'b00:   return 1'b0;
      2'b01:   return a >= 32'h18000;
      2'b10:   return a >= 32'h10000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic rdsr_chk(input logic [7:0] mask, input string req);
    bq_t rx;
    bit so;
    xfer('{8'h05, 8'h00, 8'h00}, rx, so, 1'b0);
    chk((rx[1] & mask) == (status_m() & mask), req, "status byte", rx[1], status_m());
    chk((rx[2] & mask) == (status_m() & mask), req, "status repeat", rx[2], status_m());
  endtask

  task automatic set_wen();
    cmd('{8'h06});
    wen_m = 1'b1;
  endtask

  task automatic wrsr(input logic [7:0] v);
    cmd('{8'h01, v});
    if (wen_m) begin
      pen_m = v[7];
      scr_m = v[6:4];
      bp_m  = v[3:2];
    end
    wen_m = 1'b0;
  endtask

  task automatic mem_write(input int a, input bq_t d, input string req);
    bq_t tx, rx;
    bit so;
    int aa;
    cur_req = req;
    tx = '{8'h02, 8'(a >> 16), 8'(a >> 8), 8'(a)};
    foreach (d[i]) begin
      aa = (a + i) & 32'h1FFFF;
      tx.push_back(d[i]);
      if (wen_m && !prot(aa)) begin
        wr_q.push_back('{aa, d[i]});
        exp_mem[aa] = d[i];
      end
    end
    xfer(tx, rx, so, 1'b0);
    settle(req);
    if (d.size() > 0) wen_m = 1'b0;
  endtask

  task automatic mem_read(input logic [23:0] a, input int n, input string req);
    bq_t tx, rx;
    bit so;
    int aa;
    logic [7:0] e;
    tx = '{8'h03, a[23:16], a[15:8], a[7:0]};
    for (int i = 0; i < n; i++) tx.push_back(8'h00);
    xfer(tx, rx, so, 1'b0);
    chk(so == 1'b1, req, "miso enabled during read", so, 1);
    for (int i = 0; i < n; i++) begin
      aa = (int'(a) + i) & 32'h1FFFF;
      e = exp_mem.exists(aa) ? exp_mem[aa] : 8'h00;
      chk(rx[4+i] == e, req, "read data", rx[4+i], e);
    end
  endtask

  task automatic do_reset(input logic cs_level);
    cs_n = cs_level;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wen_m = 1'b0;
    scr_m = 3'b0;
    for (int i = 0; i < 16; i++) clk_m[i] = 8'h00;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL [watchdog] run did not finish: actual=0x1 expected=0x0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    bq_t rx;
    bit so;
    // R2: chip select low through reset, then a save command with no falling edge
    do_reset(1'b0);
    chk(miso_oe == 1'b0, "R2", "miso_oe after reset", miso_oe, 0);
    chk(mem_we == 1'b0 && mem_re == 1'b0, "R2", "memory strobes after reset",
        {mem_we, mem_re}, 0);
    cur_req = "R2";
    xfer('{8'h3C}, rx, so, 1'b1);
    settle("R2");
    do_reset(1'b0);
    xfer('{8'h06}, rx, so, 1'b1);
    rdsr_chk(8'h73, "R2");

    // R4 and R5: latch control and status write
    set_wen();
    rdsr_chk(8'h73, "R4");
    cmd('{8'h04});
    wen_m = 1'b0;
    rdsr_chk(8'h73, "R4");
    set_wen();
    wrsr(8'h00);
    rdsr_chk(8'hFF, "R5");
    wrsr(8'hB4);
    rdsr_chk(8'hFF, "R5");
    set_wen();
    wrsr(8'hB7);
    rdsr_chk(8'hFF, "R8");

    // R3: reset keeps protect bits, clears latch and scratch
    set_wen();
    do_reset(1'b1);
    rdsr_chk(8'hFF, "R3");

    // R7: write without latch, then wrapping write
    set_wen();
    wrsr(8'h00);
    mem_write(32'h00100, '{8'h11}, "R7");
    set_wen();
    mem_write(32'h1FFFE, '{8'hA1, 8'hA2, 8'hA3}, "R7");
    rdsr_chk(8'hFF, "R8");
    set_wen();
    mem_write(32'h00040, '{8'h5A, 8'hC3}, "R7");

    // R6 and R14: reads with masked address and wrap
    mem_read(24'hFFFFFF, 2, "R6");
    mem_read(24'h000040, 2, "R14");
    mem_read(24'h01FFFE, 3, "R6");

    // R9: protected regions
    set_wen(); wrsr(8'h04);
    set_wen(); mem_write(32'h17FFF, '{8'h21, 8'h22}, "R9");
    set_wen(); wrsr(8'h08);
    set_wen(); mem_write(32'h0FFFF, '{8'h31, 8'h32}, "R9");
    set_wen(); wrsr(8'h0C);
    set_wen(); mem_write(32'h00010, '{8'h41}, "R9");
    cmd('{8'h04}); wen_m = 1'b0;
    mem_read(24'h017FFF, 2, "R9");
    mem_read(24'h00FFFF, 2, "R9");
    set_wen(); wrsr(8'h00);

    // R10: clock register file
    set_wen();
    cmd('{8'h12, 8'h0F, 8'h66, 8'h77});
    clk_m[15] = 8'h66; clk_m[0] = 8'h77;
    rdsr_chk(8'hFF, "R10");
    cmd('{8'h04}); wen_m = 1'b0;
    cmd('{8'h12, 8'h05, 8'h99});
    xfer('{8'h13, 8'h0F, 8'h00, 8'h00}, rx, so, 1'b0);
    chk(rx[2] == clk_m[15], "R10", "clock reg 15", rx[2], clk_m[15]);
    chk(rx[3] == clk_m[0], "R10", "clock reg wrap to 0", rx[3], clk_m[0]);
    xfer('{8'h13, 8'h05, 8'h00}, rx, so, 1'b0);
    chk(rx[2] == clk_m[5], "R10", "clock reg write without latch", rx[2], clk_m[5]);

    // R11: request pulses
    cur_req = "R11";
    pl_q.push_back(4'b0001); cmd('{8'h3C});
    pl_q.push_back(4'b0010); cmd('{8'h60});
    pl_q.push_back(4'b0100); cmd('{8'h59});
    pl_q.push_back(4'b1000); cmd('{8'h19});
    settle("R11");

    // R12: busy during command decode
    cur_req = "R12";
    busy = 1'b1;
    cmd('{8'h3C});
    cmd('{8'h06});
    xfer('{8'h05, 8'h00}, rx, so, 1'b0);
    chk(so == 1'b0, "R12", "miso enabled while busy", so, 0);
    busy = 1'b0;
    settle("R12");
    rdsr_chk(8'hFF, "R12");

    // R13 and R1: undefined/reserved commands
    cur_req = "R13";
    xfer('{8'h1E, 8'h06, 8'h3C}, rx, so, 1'b0);
    chk(so == 1'b0, "R13", "miso enabled after reserved", so, 0);
    xfer('{8'hAA, 8'h05, 8'h00}, rx, so, 1'b0);
    chk(so == 1'b0, "R13", "miso enabled after undefined", so, 0);
    settle("R13");
    rdsr_chk(8'hFF, "R1");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule